// File: doc/BRIEF.md
# Power Stage Protection Supervisor

This block sits between a set of analog comparators and the gate scheduler of a switched-mode power stage. Each comparator delivers a ready-made digital flag: supply above its start level, supply below its stop level, supply over-voltage, over-voltage on the sampled auxiliary winding, current sense above the shutdown level in the current switching cycle, and die hot together with a separate die-cooled release flag. The scheduler also supplies a strobe, one clock wide, at the end of every gate pulse. The supervisor turns these flags into a single converter enable and a sticky word that records why the converter stopped.

Each fault is qualified in its own way. The supply start/stop pair uses hysteresis. Supply over-voltage must persist for a programmable debounce window. A shorted output diode is recognised only after a run of consecutive switching cycles with the current sense over the shutdown level. Output over-voltage acts at once. None of the faults latches for good. Output over-voltage, shorted diode and supply over-voltage all lead to a timed retry. Over-temperature holds the converter off until the release flag arrives, and if the supply collapses in the meantime, the converter keeps cycling through lockout.

A four-state sequencer controls the enable: ST_LOCKOUT, ST_RUN, ST_RETRY and ST_THERMAL. Its transitions are:
- lockout-to-run: supply ok, not hot, supply over-voltage not qualified.
- lockout-to-thermal: supply ok while hot.
- run-to-lockout: supply lost.
- run-to-thermal: die hot.
- run-to-retry: supply over-voltage qualified, auxiliary over-voltage, or diode short.
- retry-to-lockout: supply lost, or the retry timer has expired.
- retry-to-thermal: die hot.
- thermal-to-lockout: supply lost (hiccup) or die cooled.

Top module: `psu_fault_supervisor`

## Requirements
- R1: After reset the enable is 0, the status word is 0 and the sequencer is in lockout.
- R2: The supply-ok state sets when the start flag is high, clears when the stop flag is high, and holds its value while both flags are low. The enable is never 1 while supply-ok is 0, and losing supply-ok while running sets status bit 0.
- R3: Supply over-voltage stops the converter only after the flag has been high for DEBOUNCE_CYCLES consecutive clocks. Any shorter burst has no effect. While qualified, it blocks the enable. It sets status bit 1.
- R4: A strobe with current sense over the shutdown level adds one to a run counter. A strobe with it below clears the counter. Reaching SHORT_CYCLES stops the converter and sets status bit 3.
- R5: Auxiliary over-voltage while running stops the converter one clock later and sets status bit 2. It is checked again on every restart, so while it persists the enable comes back in short pulses.
- R6: A die-hot flag stops the converter and sets status bit 4. The converter stays off until the die-cooled flag is seen, even after the die-hot flag drops.
- R7: If the supply drops while hot, the sequencer goes to lockout. When the supply returns, the enable stays 0 until the die has cooled.
- R8: After a retry-class fault, the enable stays 0 for RESTART_CYCLES clocks, then one lockout clock follows. After that, the enable returns if no fault is live.
- R9: Status bits are sticky, and they all clear on the clock in which the enable is next asserted.
- R10: The enable is registered. From a start flag sampled at clock edge n, the enable rises after edge n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vdd_on_i | input | 1 | Supply above start level |
| vdd_off_i | input | 1 | Supply below stop level |
| vdd_ov_i | input | 1 | Supply over-voltage comparator |
| aux_ov_i | input | 1 | Sampled auxiliary winding over-voltage |
| cs_sd_i | input | 1 | Current sense above shutdown level this cycle |
| pulse_stb_i | input | 1 | End-of-gate-pulse strobe from the scheduler |
| die_hot_i | input | 1 | Die temperature above trip level |
| die_cool_i | input | 1 | Die cooled by the release hysteresis |
| drv_enable_o | output | 1 | Converter enable |
| fault_status_o | output | 5 | Sticky causes: 0 supply lost, 1 supply OV, 2 aux OV, 3 diode short, 4 overtemp |

## Verification
The supply flags are driven as one-cycle start pulses followed by a quiet hold band and then a stop, which separates a hysteresis latch from a simple level follower. Supply over-voltage is applied once as a burst one clock short of the window and once as a sustained level, which tells a proper debounce apart from an off-by-one or immediate trip. The diode strobes include an interrupted run, five over, one under, then seven over, so a counter that fails to clear on a good cycle is exposed. A persistent auxiliary fault shows the repeating restart. The thermal test drops the hot flag before the release and removes the supply mid-fault, which distinguishes the release-flag hysteresis and the hiccup from a level-following shutdown.

// File: rtl/psu_sup_pkg.sv
package psu_sup_pkg;

    typedef enum logic [1:0] {
        ST_LOCKOUT = 2'd0,
        ST_RUN     = 2'd1,
        ST_RETRY   = 2'd2,
        ST_THERMAL = 2'd3
    } sup_state_e;

    localparam int FLT_W          = 5;
    localparam int FB_SUPPLY_LOST = 0;
    localparam int FB_SUPPLY_OV   = 1;
    localparam int FB_AUX_OV      = 2;
    localparam int FB_DIODE_SHORT = 3;
    localparam int FB_OVERTEMP    = 4;

endpackage

// File: rtl/uvlo_hysteresis.sv
module uvlo_hysteresis (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_ok_i,
    input  logic fall_low_i,
    output logic ok_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_o <= 1'b0;
        end else if (fall_low_i) begin
            ok_o <= 1'b0;
        end else if (rise_ok_i) begin
            ok_o <= 1'b1;
        end
    end

    // R2: inside the hold band the state must not move
    p_hold_band_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_ok_i && !fall_low_i) |=> $stable(ok_o));

    // R2: a stop flag always forces the state low
    p_stop_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fall_low_i |=> !ok_o);

endmodule

// File: rtl/ovp_debounce.sv
module ovp_debounce #(
    parameter int DEBOUNCE_CYCLES = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic qual_o
);

    localparam int CW = $clog2(DEBOUNCE_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DEBOUNCE_CYCLES);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!level_i) begin
            run_q <= '0;
        end else if (run_q != LIMIT) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign qual_o = (run_q == LIMIT);

    // R3: the qualified flag never outlives the raw level
    p_qual_needs_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_o && !level_i) |=> !qual_o);

    // R3: the run counter never passes its limit
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= LIMIT);

endmodule

// File: rtl/diode_short_counter.sv
module diode_short_counter #(
    parameter int SHORT_CYCLES = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic strobe_i,
    input  logic over_i,
    output logic trip_o
);

    localparam int CW = $clog2(SHORT_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SHORT_CYCLES);

    logic [CW-1:0] hits_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hits_q <= '0;
        end else if (clr_i) begin
            hits_q <= '0;
        end else if (strobe_i) begin
            if (!over_i) begin
                hits_q <= '0;
            end else if (hits_q != LIMIT) begin
                hits_q <= hits_q + 1'b1;
            end
        end
    end

    assign trip_o = (hits_q == LIMIT);

    // R4: a trip can only appear right after an over-level strobe
    p_trip_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_o) |-> $past(strobe_i && over_i));

    // R4: a good cycle empties the run
    p_good_cycle_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && !over_i) |=> !trip_o);

endmodule

// File: rtl/restart_sequencer.sv
module restart_sequencer
    import psu_sup_pkg::*;
#(
    parameter int RESTART_CYCLES = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uvlo_ok_i,
    input  logic             vdd_ov_q_i,
    input  logic             aux_ov_i,
    input  logic             short_trip_i,
    input  logic             die_hot_i,
    input  logic             die_cool_i,
    output logic             enable_o,
    output logic [FLT_W-1:0] status_o
);

    localparam int RW = (RESTART_CYCLES > 1) ? $clog2(RESTART_CYCLES) : 1;
    localparam logic [RW-1:0] RETRY_LAST = RW'(RESTART_CYCLES - 1);

    sup_state_e       state_q, state_d;
    logic             hot_q;
    logic [RW-1:0]    retry_q;
    logic             retry_done;
    logic             retry_fault;
    logic             run_entry;
    logic [FLT_W-1:0] live;

    // thermal hysteresis: trip flag sets, release flag clears
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hot_q <= 1'b0;
        end else if (die_hot_i) begin
            hot_q <= 1'b1;
        end else if (die_cool_i) begin
            hot_q <= 1'b0;
        end
    end

    assign retry_done  = (retry_q == RETRY_LAST);
    assign retry_fault = vdd_ov_q_i || aux_ov_i || short_trip_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKOUT: begin
                if (uvlo_ok_i) begin
                    if (hot_q)            state_d = ST_THERMAL;
                    else if (!vdd_ov_q_i) state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (!uvlo_ok_i)       state_d = ST_LOCKOUT;
                else if (hot_q)       state_d = ST_THERMAL;
                else if (retry_fault) state_d = ST_RETRY;
            end
            ST_RETRY: begin
                if (!uvlo_ok_i)      state_d = ST_LOCKOUT;
                else if (hot_q)      state_d = ST_THERMAL;
                else if (retry_done) state_d = ST_LOCKOUT;
            end
            ST_THERMAL: begin
                if (!uvlo_ok_i || !hot_q) state_d = ST_LOCKOUT;
            end
            default: state_d = ST_LOCKOUT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCKOUT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            retry_q <= '0;
        end else if (state_q != ST_RETRY) begin
            retry_q <= '0;
        end else if (!retry_done) begin
            retry_q <= retry_q + 1'b1;
        end
    end

    // output decode
    always_comb begin
        enable_o = (state_q == ST_RUN);
    end

    assign run_entry = (state_q != ST_RUN) && (state_d == ST_RUN);

    always_comb begin
        live                 = '0;
        live[FB_SUPPLY_LOST] = (state_q == ST_RUN) && !uvlo_ok_i;
        live[FB_SUPPLY_OV]   = vdd_ov_q_i;
        live[FB_AUX_OV]      = aux_ov_i;
        live[FB_DIODE_SHORT] = short_trip_i;
        live[FB_OVERTEMP]    = hot_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_o <= '0;
        end else if (run_entry) begin
            status_o <= '0;
        end else begin
            status_o <= status_o | live;
        end
    end

    // R2: no enable without supply ok
    p_uvlo_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !uvlo_ok_i |=> !enable_o);

    // R3: a qualified supply over-voltage blocks the enable
    p_ovp_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vdd_ov_q_i |=> !enable_o);

    // R6: a hot die blocks the enable
    p_hot_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hot_q |=> !enable_o);

    // R7: leaving thermal hold without cooling only happens through lockout
    p_hiccup_path_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_THERMAL && hot_q && !die_cool_i) |=> (state_q != ST_RUN));

    // R8: retry timer stays inside its window
    p_retry_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        retry_q <= RETRY_LAST);

    // R9: status is clean whenever the enable rises
    p_entry_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable_o) |-> (status_o == '0));

endmodule

// File: rtl/psu_fault_supervisor.sv
module psu_fault_supervisor
    import psu_sup_pkg::*;
#(
    parameter int DEBOUNCE_CYCLES = 2500,
    parameter int SHORT_CYCLES    = 7,
    parameter int RESTART_CYCLES  = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vdd_on_i,
    input  logic             vdd_off_i,
    input  logic             vdd_ov_i,
    input  logic             aux_ov_i,
    input  logic             cs_sd_i,
    input  logic             pulse_stb_i,
    input  logic             die_hot_i,
    input  logic             die_cool_i,
    output logic             drv_enable_o,
    output logic [FLT_W-1:0] fault_status_o
);

    logic uvlo_ok;
    logic vdd_ov_q;
    logic short_trip;

    uvlo_hysteresis u_uvlo (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_ok_i  (vdd_on_i),
        .fall_low_i (vdd_off_i),
        .ok_o       (uvlo_ok)
    );

    ovp_debounce #(
        .DEBOUNCE_CYCLES (DEBOUNCE_CYCLES)
    ) u_vdd_ovp (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (vdd_ov_i),
        .qual_o  (vdd_ov_q)
    );

    diode_short_counter #(
        .SHORT_CYCLES (SHORT_CYCLES)
    ) u_short (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (!drv_enable_o),
        .strobe_i (pulse_stb_i),
        .over_i   (cs_sd_i),
        .trip_o   (short_trip)
    );

    restart_sequencer #(
        .RESTART_CYCLES (RESTART_CYCLES)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .uvlo_ok_i    (uvlo_ok),
        .vdd_ov_q_i   (vdd_ov_q),
        .aux_ov_i     (aux_ov_i),
        .short_trip_i (short_trip),
        .die_hot_i    (die_hot_i),
        .die_cool_i   (die_cool_i),
        .enable_o     (drv_enable_o),
        .status_o     (fault_status_o)
    );

    // R1: nothing runs in the cycle after reset release
    p_reset_quiet_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!drv_enable_o && fault_status_o == '0));

endmodule

// File: tb/psu_fault_supervisor_test.sv
module psu_fault_supervisor_test;

    localparam int DEB = 20;
    localparam int SHC = 7;
    localparam int RST_C = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vdd_on = 1'b0, vdd_off = 1'b0, vdd_ov = 1'b0, aux_ov = 1'b0;
    logic cs_sd = 1'b0, stb = 1'b0, hot = 1'b0, cool = 1'b0;
    logic       en;
    logic [4:0] st;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    psu_fault_supervisor #(
        .DEBOUNCE_CYCLES (DEB),
        .SHORT_CYCLES    (SHC),
        .RESTART_CYCLES  (RST_C)
    ) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .vdd_on_i       (vdd_on),
        .vdd_off_i      (vdd_off),
        .vdd_ov_i       (vdd_ov),
        .aux_ov_i       (aux_ov),
        .cs_sd_i        (cs_sd),
        .pulse_stb_i    (stb),
        .die_hot_i      (hot),
        .die_cool_i     (cool),
        .drv_enable_o   (en),
        .fault_status_o (st)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_run();
        vdd_on = 1'b1; vdd_off = 1'b0;
        cyc(1);
        vdd_on = 1'b0;
        cyc(2);
    endtask

    task automatic t_reset();
        cyc(2);
        chk("R1 enable", en, 0);
        chk("R1 status", st, 0);
        rst_n = 1'b1;
        cyc(3);
        chk("R1 idle after release", en, 0);
    endtask

    task automatic t_uvlo();
        vdd_on = 1'b1;
        cyc(1);
        vdd_on = 1'b0;
        chk("R10 one edge after start", en, 0);
        cyc(1);
        chk("R10 enable after two edges", en, 1);
        chk("R9 status clear on enable", st, 0);
        cyc(6);
        chk("R2 holds in band", en, 1);
        vdd_off = 1'b1;
        cyc(1);
        chk("R2 stop latency", en, 1);
        cyc(1);
        chk("R2 stopped", en, 0);
        chk("R2 supply-lost bit0", st, 5'b00001);
        vdd_off = 1'b0;
        cyc(6);
        chk("R2 stays off in band", en, 0);
    endtask

    task automatic t_vdd_ovp();
        go_run();
        vdd_ov = 1'b1;
        cyc(DEB - 1);
        vdd_ov = 1'b0;
        cyc(4);
        chk("R3 short burst ignored", en, 1);
        vdd_ov = 1'b1;
        cyc(DEB);
        chk("R3 not before window", en, 1);
        cyc(1);
        chk("R3 trip after window", en, 0);
        chk("R3 status bit1", st, 5'b00010);
        cyc(RST_C + 6);
        chk("R3 held off while present", en, 0);
        vdd_ov = 1'b0;
        cyc(RST_C + 3);
        chk("R8 restart after OV clears", en, 1);
        chk("R9 cleared on restart", st, 0);
    endtask

    task automatic strobe(input logic over);
        cs_sd = over; stb = 1'b1;
        cyc(1);
        stb = 1'b0; cs_sd = 1'b0;
        cyc(1);
    endtask

    task automatic t_diode();
        for (int i = 0; i < 5; i++) strobe(1'b1);
        strobe(1'b0);
        for (int i = 0; i < SHC - 1; i++) strobe(1'b1);
        chk("R4 run reset by good cycle", en, 1);
        cs_sd = 1'b1; stb = 1'b1;
        cyc(1);
        stb = 1'b0; cs_sd = 1'b0;
        chk("R4 trip latency", en, 1);
        cyc(1);
        chk("R4 shutdown on run", en, 0);
        chk("R4 status bit3", st, 5'b01000);
        cyc(RST_C - 2);
        chk("R8 still in retry", en, 0);
        cyc(3);
        chk("R8 restarted", en, 1);
    endtask

    task automatic t_aux();
        int rises;
        logic prev;
        aux_ov = 1'b1;
        cyc(1);
        chk("R5 immediate stop", en, 0);
        chk("R5 status bit2", st, 5'b00100);
        rises = 0;
        prev = en;
        for (int i = 0; i < 60; i++) begin
            cyc(1);
            if (en && !prev) rises++;
            prev = en;
        end
        chk("R5 repeated restart attempts", (rises >= 2), 1);
        aux_ov = 1'b0;
        cyc(RST_C + 4);
        chk("R5 recovers", en, 1);
    endtask

    task automatic t_thermal();
        hot = 1'b1;
        cyc(1);
        hot = 1'b0;
        cyc(1);
        chk("R6 stop on hot", en, 0);
        chk("R6 status bit4", st, 5'b10000);
        cyc(10);
        chk("R6 no release without cool flag", en, 0);
        vdd_off = 1'b1;
        cyc(3);
        vdd_off = 1'b0;
        vdd_on = 1'b1;
        cyc(1);
        vdd_on = 1'b0;
        cyc(6);
        chk("R7 hiccup keeps off while hot", en, 0);
        cool = 1'b1;
        cyc(1);
        cool = 1'b0;
        cyc(2);
        chk("R6 release after cool", en, 1);
        chk("R9 cleared", st, 0);
    endtask

    initial begin
        t_reset();
        t_uvlo();
        t_vdd_ovp();
        t_diode();
        t_aux();
        t_thermal();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule